// File: doc/BRIEF.md
# Masked-Minimum Rule Inference with Weighted-Centre Defuzzifier

The block is the back end of a pipelined fuzzy processor. For every active rule it is given the four input membership degrees of the current input set (4 bits each) together with a 7-bit rule word. It takes the minimum of the degrees of the inputs that the rule names and multiplies that strength by a programmable weight. It then adds the strength-weight product, and the same product scaled by the centre of the rule's output set, into two running sums. One rule is taken every clock cycle.

A first-rule flag restarts both sums and a last-rule flag closes the input set. When a set closes, the two sums go to a sequential restoring divider. The divider produces the 7-bit crisp output while the rules of the next set are already being accumulated. A table of eight output-set centres and eight weights, one pair per output set and indexed by the consequent code, is written through a small configuration port.

Top module: `fuzzy_infer_defuzz`

## Requirements
- R1: The rule word is `rule_prem` (bit i enables input i, whose degree is `rule_deg[4i+3:4i]`) plus the 3-bit `rule_cons`, which selects one of 8 output sets and thereby its centre and its weight.
- R2: An input whose enable bit is 0 is treated as degree 15 (full truth), so its degree value has no effect on the output.
- R3: The rule strength is the minimum of the degrees of all enabled inputs.
- R4: A rule with `rule_prem` = 0000 has strength 0 and changes neither sum.
- R5: For each rule accepted with `rule_valid`, the denominator grows by strength*weight and the numerator by centre*strength*weight. A rule flagged with `rule_first` replaces the previous sums instead of adding to them.
- R6: For a rule flagged with `rule_last`, the output is floor(numerator/denominator), with both sums including that rule. `out_valid` pulses for one cycle exactly 8 cycles after the cycle in which that rule was presented.
- R7: A set whose denominator is 0 produces output 0.
- R8: Rules are accepted every cycle while a division is in progress, so an input set of 8 or more rules can follow the previous one with no idle cycles.
- R9: With `cfg_we` high, centre `cfg_centre` and weight `cfg_weight` are written for output set `cfg_sel`, and rules presented after that write use the new values.
- R10: After reset, `out_valid` and `out_value` are 0 and every centre and weight is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write enable for the centre/weight table |
| cfg_sel | input | 3 | Output set being written |
| cfg_centre | input | 7 | Centre value to write |
| cfg_weight | input | 4 | Weight value to write |
| rule_valid | input | 1 | A rule is presented this cycle |
| rule_first | input | 1 | Rule is the first of its input set |
| rule_last | input | 1 | Rule is the last of its input set |
| rule_deg | input | 16 | Four input degrees, input i in bits 4i+3:4i |
| rule_prem | input | 4 | Per-input enable bits of the rule |
| rule_cons | input | 3 | Consequent output-set code |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_value | output | 7 | Defuzzified output |

## Verification
All sixteen enable codes are swept against random degrees. Each mask is therefore checked for the degree it is supposed to ignore as well as the one it uses, which separates a wrong mask polarity from a wrong minimum. Hand-built sets isolate three cases: a single enabled input with all other degrees at zero (the masking), sets made only of padding rules (the zero-denominator output), and padding rules placed first in a set (the restart of the sums). Long sets are sent back to back, so each division runs while the next set is being summed; results checked against both value and arrival cycle show whether the overlap corrupts either one. A reprogrammed centre and weight, and the all-15 degree corner, complete the patterns.

// File: rtl/fuzzy_infer_defuzz.sv
module fuzzy_infer_defuzz #(
  parameter int NIN = 4,
  parameter int DW  = 4,
  parameter int OW  = 7,
  parameter int CSW = 3,
  parameter int WW  = 4,
  parameter int RB  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CSW-1:0]     cfg_sel,
  input  logic [OW-1:0]      cfg_centre,
  input  logic [WW-1:0]      cfg_weight,
  input  logic               rule_valid,
  input  logic               rule_first,
  input  logic               rule_last,
  input  logic [NIN*DW-1:0]  rule_deg,
  input  logic [NIN-1:0]     rule_prem,
  input  logic [CSW-1:0]     rule_cons,
  output logic               out_valid,
  output logic [OW-1:0]      out_value
);
  localparam int NSET = 1 << CSW;
  localparam int SW   = DW + WW;
  localparam int NUMW = OW + SW + RB;
  localparam int DENW = SW + RB;
  localparam int CNTW = $clog2(OW);
  localparam int XW   = NUMW + OW;

  logic [OW-1:0] centre [NSET];
  logic [WW-1:0] weight [NSET];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NSET; k++) begin
        centre[k] <= '0;
        weight[k] <= '0;
      end
    end else if (cfg_we) begin
      centre[cfg_sel] <= cfg_centre;
      weight[cfg_sel] <= cfg_weight;
    end
  end

  logic [DW-1:0] str;
  always_comb begin
    str = '1;
    for (int i = 0; i < NIN; i++)
      if (rule_prem[i] && rule_deg[i*DW +: DW] < str) str = rule_deg[i*DW +: DW];
    if (rule_prem == '0) str = '0;
  end

  logic [SW-1:0]    sw;
  logic [OW+SW-1:0] cterm;
  assign sw    = {{WW{1'b0}}, str} * {{DW{1'b0}}, weight[rule_cons]};
  assign cterm = {{SW{1'b0}}, centre[rule_cons]} * {{OW{1'b0}}, sw};

  logic [NUMW-1:0] acc_num, num_nx;
  logic [DENW-1:0] acc_den, den_nx;
  assign num_nx = (rule_first ? '0 : acc_num) + {{RB{1'b0}}, cterm};
  assign den_nx = (rule_first ? '0 : acc_den) + {{RB{1'b0}}, sw};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_num <= '0;
      acc_den <= '0;
    end else if (rule_valid) begin
      acc_num <= num_nx;
      acc_den <= den_nx;
    end
  end

  logic            busy;
  logic [CNTW-1:0] cnt;
  logic [NUMW-1:0] rem;
  logic [DENW-1:0] dsr;
  logic [OW-1:0]   q;
  logic [XW-1:0]   shv;
  logic            qbit;

  assign shv  = {{(XW-DENW){1'b0}}, dsr} << cnt;
  assign qbit = {{OW{1'b0}}, rem} >= shv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      rem       <= '0;
      dsr       <= '0;
      q         <= '0;
      out_valid <= 1'b0;
      out_value <= '0;
    end else begin
      out_valid <= 1'b0;
      if (rule_valid && rule_last) begin
        busy <= 1'b1;
        cnt  <= CNTW'(OW - 1);
        rem  <= num_nx;
        dsr  <= den_nx;
        q    <= '0;
      end else if (busy) begin
        if (qbit) rem <= rem - shv[NUMW-1:0];
        q <= {q[OW-2:0], qbit};
        if (cnt == '0) begin
          busy      <= 1'b0;
          out_valid <= 1'b1;
          out_value <= (dsr == '0) ? '0 : {q[OW-2:0], qbit};
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fuzzy_infer_defuzz_chk.sv
module fuzzy_infer_defuzz_chk #(
  parameter int NUMW = 19,
  parameter int DENW = 12,
  parameter int CNTW = 3,
  parameter int NIN  = 4,
  parameter int OW   = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rule_valid,
  input logic            rule_first,
  input logic            rule_last,
  input logic [NIN-1:0]  rule_prem,
  input logic [NUMW-1:0] acc_num,
  input logic [DENW-1:0] acc_den,
  input logic            busy,
  input logic [CNTW-1:0] cnt,
  input logic [DENW-1:0] dsr,
  input logic            out_valid,
  input logic [OW-1:0]   out_value
);
  // R4
  padding_keeps_sums_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rule_valid && !rule_first && rule_prem == '0 |=>
      acc_num == $past(acc_num) && acc_den == $past(acc_den));

  // R5
  first_padding_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rule_valid && rule_first && rule_prem == '0 |=> acc_num == '0 && acc_den == '0);

  // R6
  last_starts_divide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rule_valid && rule_last |=> busy);

  // R6
  result_after_final_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(busy) && $past(cnt) == '0);

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R7
  zero_den_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt == '0 && dsr == '0 && !(rule_valid && rule_last) |=> out_value == '0);
endmodule

bind fuzzy_infer_defuzz fuzzy_infer_defuzz_chk #(
  .NUMW(NUMW), .DENW(DENW), .CNTW(CNTW), .NIN(NIN), .OW(OW)
) i_chk (
  .clk(clk), .rst_n(rst_n), .rule_valid(rule_valid), .rule_first(rule_first),
  .rule_last(rule_last), .rule_prem(rule_prem), .acc_num(acc_num), .acc_den(acc_den),
  .busy(busy), .cnt(cnt), .dsr(dsr), .out_valid(out_valid), .out_value(out_value)
);

// File: tb/test_fuzzy_infer_defuzz.sv
module test_fuzzy_infer_defuzz;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [6:0]  cfg_centre = '0;
  logic [3:0]  cfg_weight = '0;
  logic        rule_valid = 1'b0, rule_first = 1'b0, rule_last = 1'b0;
  logic [15:0] rule_deg = '0;
  logic [3:0]  rule_prem = '0;
  logic [2:0]  rule_cons = '0;
  logic        out_valid;
  logic [6:0]  out_value;

  fuzzy_infer_defuzz i_fuzzy_infer_defuzz (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int exp_val [512];
  int exp_cyc [512];
  string exp_tag [512];
  int wr = 0, rd = 0;
  int mc [8];
  int mw [8];
  longint snum, sden;
  int lcg = 32'h1234_5678;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rnd();
    lcg = lcg * 1103515245 + 12345;
    return (lcg >>> 8) & 32'hFFFF;
  endfunction

  always @(negedge clk) if (rst_n && out_valid) begin
    if (rd < wr) begin
      check({exp_tag[rd], " value"}, int'(out_value), exp_val[rd]);
      check("R6 latency", cyc - exp_cyc[rd], 8);
      rd++;
    end else check("R6 unexpected result", 1, 0);
  end

  task automatic cfg(int s, int c, int w);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'(s); cfg_centre = 7'(c); cfg_weight = 4'(w);
    mc[s] = c; mw[s] = w;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rule(logic [15:0] d, logic [3:0] p, int c, bit f, bit l, string tag);
    int s;
    @(negedge clk);
    rule_valid = 1; rule_first = f; rule_last = l;
    rule_deg = d; rule_prem = p; rule_cons = 3'(c);
    s = 15;
    for (int i = 0; i < 4; i++) if (p[i] && int'(d[4*i +: 4]) < s) s = int'(d[4*i +: 4]);
    if (p == 0) s = 0;
    if (f) begin snum = 0; sden = 0; end
    snum += longint'(mc[c] * mw[c] * s);
    sden += longint'(mw[c] * s);
    if (l) begin
      exp_val[wr] = (sden == 0) ? 0 : int'(snum / sden);
      exp_cyc[wr] = cyc;
      exp_tag[wr] = tag;
      wr++;
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    rule_valid = 0; rule_first = 0; rule_last = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10
    check("R10 out_valid", int'(out_valid), 0);
    check("R10 out_value", int'(out_value), 0);
    rst_n = 1;
    // R10: empty table gives zero denominator
    rule(16'hFFFF, 4'hF, 2, 1, 1, "R10 table reset");
    idle(10);
    for (int k = 0; k < 8; k++) cfg(k, k * 18, k + 8);

    // R1 R2: single enabled input, others at degree 0 but ignored
    rule(16'h0009, 4'b0001, 3, 1, 1, "R2 mask input0");
    idle(10);
    rule(16'h0C00, 4'b0100, 6, 1, 1, "R1 input2 set6");
    idle(10);
    // R1 R3: one rule per input, different degrees
    rule(16'h0005, 4'b0001, 0, 1, 0, "R1");
    rule(16'h00A0, 4'b0010, 1, 0, 0, "R1");
    rule(16'h0300, 4'b0100, 2, 0, 0, "R1");
    rule(16'hF000, 4'b1000, 7, 0, 1, "R1 per-input enable");
    idle(10);
    // R4 R7: only padding rules
    rule(16'hFFFF, 4'b0000, 5, 1, 0, "R7");
    rule(16'h7777, 4'b0000, 7, 0, 1, "R7 all padding");
    idle(10);
    // R4 R5: padding rule first, then live rules
    rule(16'hFFFF, 4'b0000, 7, 1, 0, "R4");
    rule(16'h2468, 4'b1111, 1, 0, 0, "R4");
    rule(16'hFFFF, 4'b0000, 0, 0, 1, "R4 padding first");
    idle(10);
    // R3: all 16 enable codes against random degrees
    for (int s = 0; s < 8; s++) begin
      for (int j = 0; j < 16; j++)
        rule(16'(rnd()), 4'(j), rnd() % 8, j == 0, j == 15, "R3 mask sweep");
    end
    idle(10);
    // R5 R8: back-to-back long sets, divide overlaps next set
    for (int s = 0; s < 48; s++) begin
      int n;
      n = 8 + (s % 9);
      for (int j = 0; j < n; j++)
        rule(16'(rnd()), 4'(rnd()), rnd() % 8, j == 0, j == n - 1, "R8 overlap");
    end
    idle(10);
    // R9: reprogram one set
    cfg(5, 100, 1);
    rule(16'h3333, 4'b1111, 5, 1, 0, "R9");
    rule(16'h1111, 4'b0011, 0, 0, 1, "R9 reprogrammed");
    idle(10);
    // R3: all-15 degrees
    rule(16'hFFFF, 4'b1111, 7, 1, 1, "R3 full degrees");
    idle(12);
    check("R6 result count", rd, wr);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule